// File: doc/BRIEF.md
# Clock Mode Sequencing Controller

This block is the control state machine for a clock generator that can run in four operating modes. The modes combine a frequency-locked loop that is either engaged or bypassed with a reference that is either internal or external. Software reaches the block through a single configuration write port. One write carries a clock-source selector, a reference-select bit, a reference divider, an output divider and an enable for the external clock source. The controller accepts a write only if it decodes to a known mode and the move from the current mode is permitted. Otherwise it keeps its state and raises a one-cycle error pulse.

The analog parts are modelled by timers. After reset a stabilisation counter must expire before a lock counter may run, and the lock flag rises when the lock counter expires. Switching the reference clears lock and restarts the lock counter. Status copies of the source selector and the reference bit trail the control bits by a fixed switch latency, so software can poll them before relying on a new mode. The block also flags whether the divided reference, used as a fixed-frequency clock, is slow enough to be valid. It also holds a coarse and a fine trim value, which change only when software writes them.

Top module: `clkseq_ctrl`

## Requirements
- R1: After reset the mode is internal-loop (mode code 0). The source selector is 00, the reference bit is 1 (internal), the reference divider is 0, the output divider is 01 (divide by 2) and the external enable is 0. The status fields are 00 and 1, cfg_err is 0, and the trim values are TRIM_RST (coarse) and 0 (fine).
- R2: An accepted write decodes into a mode as follows. Selector 00 with reference bit 1 gives internal-loop (code 0). Selector 00 with reference bit 0 gives external-loop (code 1). Selector 10 with reference bit 0 gives external-bypass (code 2). Selector 01 with reference bit 1 gives internal-bypass (code 3). Selector 11, selector 01 with reference bit 0, and selector 10 with reference bit 1 are rejected.
- R3: A direct move between external-loop (1) and internal-bypass (3) is rejected in both directions. Every other move is accepted, including every move out of internal-loop.
- R4: A write that selects external-loop or external-bypass is accepted only if the external enable was already 1 before the write and the write itself also carries enable 1.
- R5: A rejected write leaves the mode and every control field unchanged, and cfg_err is high for exactly the one cycle after the write edge. An accepted write updates all control fields and the mode at its write edge.
- R6: ref_rdy rises STAB_CYC clock edges after reset release. locked rises LOCK_CYC edges after that.
- R7: An accepted write that changes the reference bit drops locked at its write edge. locked returns LOCK_CYC edges later.
- R8: stat_src and stat_ref_int take the new control values SW_LAT edges after the accepted write edge and hold their old values before then. Any accepted write restarts this latency.
- R9: In the bypass modes (codes 2 and 3), ffclk_ok is 0 when the output divider is 00 and the reference divider is below 2, and also when the output divider is 01 and the reference divider is below 3. In every other case ffclk_ok is 1, and it is always 1 in the loop modes.
- R10: The trim values load from trim_coarse_in and trim_fine_in only at an edge where trim_wr is high. Configuration writes and the passage of time leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src_sel | input | 2 | Requested clock-source selector |
| cfg_ref_int | input | 1 | Requested reference (1 = internal) |
| cfg_ref_div | input | REF_DIV_W | Requested reference divider code |
| cfg_out_div | input | OUT_DIV_W | Requested output divider code |
| cfg_ext_en | input | 1 | Requested external source enable |
| trim_wr | input | 1 | Trim write strobe |
| trim_coarse_in | input | TRIM_W | Coarse trim write data |
| trim_fine_in | input | 1 | Fine trim write data |
| mode | output | 2 | Current mode code |
| src_sel | output | 2 | Applied clock-source selector |
| ref_int | output | 1 | Applied reference bit |
| ref_div | output | REF_DIV_W | Applied reference divider |
| out_div | output | OUT_DIV_W | Applied output divider |
| ext_en | output | 1 | Applied external enable |
| stat_src | output | 2 | Status copy of the source selector, delayed |
| stat_ref_int | output | 1 | Status copy of the reference bit, delayed |
| ref_rdy | output | 1 | Reference stabilisation finished |
| locked | output | 1 | Loop lock declared |
| cfg_err | output | 1 | One-cycle pulse after a rejected write |
| ffclk_ok | output | 1 | Fixed-frequency clock valid |
| trim_coarse | output | TRIM_W | Coarse trim value |
| trim_fine | output | 1 | Fine trim value |

## Verification
On every cycle the assertions check several properties. The error pulse must follow a write, and a rejected write must leave the mode and dividers untouched. The mode must never move directly between external-loop and internal-bypass, and an external mode must never be held with the enable low. The assertions also check that lock never precedes reference readiness, that lock drops on a reference change, that status changes only toward the control value, and that the trim is held without a trim write. Some properties need scenarios in the bench. These are the exact decode and legality of all 64 start-mode and write combinations, the precise cycle counts of stabilisation, lock, relock and status latency, and the full divider sweep of the fixed-frequency flag in each mode.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
    typedef enum logic [1:0] {
        MODE_LOOP_INT = 2'd0,
        MODE_LOOP_EXT = 2'd1,
        MODE_BYP_EXT  = 2'd2,
        MODE_BYP_INT  = 2'd3
    } clk_mode_e;

    localparam logic [1:0] SRC_LOOP    = 2'b00;
    localparam logic [1:0] SRC_BYP_INT = 2'b01;
    localparam logic [1:0] SRC_BYP_EXT = 2'b10;
endpackage

// File: rtl/clkseq_decode.sv
module clkseq_decode
    import clkseq_pkg::*;
(
    input  clk_mode_e  cur_mode,
    input  logic       cur_ext_en,
    input  logic [1:0] wr_src,
    input  logic       wr_ref_int,
    input  logic       wr_ext_en,
    output clk_mode_e  tgt_mode,
    output logic       legal
);
    logic known;
    logic needs_ext;
    logic ext_ok;
    logic hop_bad;

    always_comb begin
        known    = 1'b1;
        tgt_mode = cur_mode;
        case (wr_src)
            SRC_LOOP:    tgt_mode = wr_ref_int ? MODE_LOOP_INT : MODE_LOOP_EXT;
            SRC_BYP_INT: begin tgt_mode = MODE_BYP_INT; known = wr_ref_int;  end
            SRC_BYP_EXT: begin tgt_mode = MODE_BYP_EXT; known = !wr_ref_int; end
            default:     known = 1'b0;
        endcase
        needs_ext = (tgt_mode == MODE_LOOP_EXT) || (tgt_mode == MODE_BYP_EXT);
        ext_ok    = !needs_ext || (cur_ext_en && wr_ext_en);
        hop_bad   = ((cur_mode == MODE_LOOP_EXT) && (tgt_mode == MODE_BYP_INT)) ||
                    ((cur_mode == MODE_BYP_INT)  && (tgt_mode == MODE_LOOP_EXT));
        legal     = known && ext_ok && !hop_bad;
    end
endmodule

// File: rtl/clkseq_timer.sv
module clkseq_timer #(
    parameter int STAB_CYC = 40,
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic relock,
    output logic ref_rdy,
    output logic locked
);
    localparam int STAB_W = $clog2(STAB_CYC + 1);
    localparam int LOCK_W = $clog2(LOCK_CYC + 1);
    localparam logic [STAB_W-1:0] STAB_END = STAB_W'(STAB_CYC);
    localparam logic [LOCK_W-1:0] LOCK_END = LOCK_W'(LOCK_CYC);

    logic [STAB_W-1:0] stab_d, stab_q;
    logic [LOCK_W-1:0] lock_d, lock_q;

    always_comb begin
        stab_d = stab_q;
        lock_d = lock_q;
        if (stab_q != STAB_END) stab_d = stab_q + 1'b1;
        if (relock)
            lock_d = '0;
        else if ((stab_q == STAB_END) && (lock_q != LOCK_END))
            lock_d = lock_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stab_q <= '0;
            lock_q <= '0;
        end else begin
            stab_q <= stab_d;
            lock_q <= lock_d;
        end
    end

    assign ref_rdy = (stab_q == STAB_END);
    assign locked  = (lock_q == LOCK_END);
endmodule

// File: rtl/clkseq_ffcheck.sv
module clkseq_ffcheck #(
    parameter int REF_DIV_W = 3,
    parameter int OUT_DIV_W = 2
) (
    input  logic                 bypass,
    input  logic [REF_DIV_W-1:0] ref_div,
    input  logic [OUT_DIV_W-1:0] out_div,
    output logic                 ok
);
    logic too_fast;

    always_comb begin
        too_fast = 1'b0;
        if (out_div == OUT_DIV_W'(0)) too_fast = (ref_div < REF_DIV_W'(2));
        if (out_div == OUT_DIV_W'(1)) too_fast = (ref_div < REF_DIV_W'(3));
        ok = !(bypass && too_fast);
    end
endmodule

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
    import clkseq_pkg::*;
#(
    parameter int STAB_CYC  = 40,
    parameter int LOCK_CYC  = 200,
    parameter int SW_LAT    = 8,
    parameter int REF_DIV_W = 3,
    parameter int OUT_DIV_W = 2,
    parameter int TRIM_W    = 8,
    parameter int TRIM_RST  = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_src_sel,
    input  logic                 cfg_ref_int,
    input  logic [REF_DIV_W-1:0] cfg_ref_div,
    input  logic [OUT_DIV_W-1:0] cfg_out_div,
    input  logic                 cfg_ext_en,
    input  logic                 trim_wr,
    input  logic [TRIM_W-1:0]    trim_coarse_in,
    input  logic                 trim_fine_in,
    output logic [1:0]           mode,
    output logic [1:0]           src_sel,
    output logic                 ref_int,
    output logic [REF_DIV_W-1:0] ref_div,
    output logic [OUT_DIV_W-1:0] out_div,
    output logic                 ext_en,
    output logic [1:0]           stat_src,
    output logic                 stat_ref_int,
    output logic                 ref_rdy,
    output logic                 locked,
    output logic                 cfg_err,
    output logic                 ffclk_ok,
    output logic [TRIM_W-1:0]    trim_coarse,
    output logic                 trim_fine
);
    localparam int SW_W = $clog2(SW_LAT + 1);
    localparam logic [SW_W-1:0] SW_LAST = SW_W'(SW_LAT - 1);

    typedef struct packed {
        clk_mode_e              mode;
        logic [1:0]             src;
        logic                   ref_int;
        logic [REF_DIV_W-1:0]   ref_div;
        logic [OUT_DIV_W-1:0]   out_div;
        logic                   ext_en;
        logic [1:0]             stat_src;
        logic                   stat_ref;
        logic [SW_W-1:0]        sw_cnt;
        logic                   err;
        logic [TRIM_W-1:0]      trim_c;
        logic                   trim_f;
    } state_t;

    state_t    d, q;
    clk_mode_e tgt_mode;
    logic      legal;
    logic      accept;
    logic      relock;

    clkseq_decode u_decode (
        .cur_mode   (q.mode),
        .cur_ext_en (q.ext_en),
        .wr_src     (cfg_src_sel),
        .wr_ref_int (cfg_ref_int),
        .wr_ext_en  (cfg_ext_en),
        .tgt_mode   (tgt_mode),
        .legal      (legal)
    );

    assign accept = cfg_wr && legal;
    assign relock = accept && (cfg_ref_int != q.ref_int);

    always_comb begin
        d     = q;
        d.err = 1'b0;
        if (cfg_wr) begin
            if (legal) begin
                d.mode    = tgt_mode;
                d.src     = cfg_src_sel;
                d.ref_int = cfg_ref_int;
                d.ref_div = cfg_ref_div;
                d.out_div = cfg_out_div;
                d.ext_en  = cfg_ext_en;
            end else begin
                d.err = 1'b1;
            end
        end
        // status lags the applied control bits by SW_LAT edges
        if (accept) begin
            d.sw_cnt = '0;
        end else if ((q.stat_src != q.src) || (q.stat_ref != q.ref_int)) begin
            if (q.sw_cnt == SW_LAST) begin
                d.stat_src = q.src;
                d.stat_ref = q.ref_int;
                d.sw_cnt   = '0;
            end else begin
                d.sw_cnt = q.sw_cnt + 1'b1;
            end
        end
        if (trim_wr) begin
            d.trim_c = trim_coarse_in;
            d.trim_f = trim_fine_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode     <= MODE_LOOP_INT;
            q.src      <= SRC_LOOP;
            q.ref_int  <= 1'b1;
            q.ref_div  <= '0;
            q.out_div  <= OUT_DIV_W'(1);
            q.ext_en   <= 1'b0;
            q.stat_src <= SRC_LOOP;
            q.stat_ref <= 1'b1;
            q.sw_cnt   <= '0;
            q.err      <= 1'b0;
            q.trim_c   <= TRIM_W'(TRIM_RST);
            q.trim_f   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    clkseq_timer #(.STAB_CYC(STAB_CYC), .LOCK_CYC(LOCK_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .relock  (relock),
        .ref_rdy (ref_rdy),
        .locked  (locked)
    );

    clkseq_ffcheck #(.REF_DIV_W(REF_DIV_W), .OUT_DIV_W(OUT_DIV_W)) u_ffcheck (
        .bypass  ((q.mode == MODE_BYP_EXT) || (q.mode == MODE_BYP_INT)),
        .ref_div (q.ref_div),
        .out_div (q.out_div),
        .ok      (ffclk_ok)
    );

    assign mode         = q.mode;
    assign src_sel      = q.src;
    assign ref_int      = q.ref_int;
    assign ref_div      = q.ref_div;
    assign out_div      = q.out_div;
    assign ext_en       = q.ext_en;
    assign stat_src     = q.stat_src;
    assign stat_ref_int = q.stat_ref;
    assign cfg_err      = q.err;
    assign trim_coarse  = q.trim_c;
    assign trim_fine    = q.trim_f;
endmodule

// File: rtl/clkseq_checker.sv
module clkseq_checker #(
    parameter int REF_DIV_W = 3,
    parameter int TRIM_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_wr,
    input logic                 trim_wr,
    input logic [1:0]           mode,
    input logic                 ref_int,
    input logic [REF_DIV_W-1:0] ref_div,
    input logic                 ext_en,
    input logic                 stat_ref_int,
    input logic                 ref_rdy,
    input logic                 locked,
    input logic                 cfg_err,
    input logic                 ffclk_ok,
    input logic [TRIM_W-1:0]    trim_coarse,
    input logic                 trim_fine
);
    p_err_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_wr));

    p_reject_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (mode == $past(mode)) && (ref_div == $past(ref_div)));

    p_no_hop_from_ext_loop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |=> (mode != 2'd3));

    p_no_hop_from_int_byp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> (mode != 2'd1));

    p_ext_mode_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd1) || (mode == 2'd2)) |-> ext_en);

    p_lock_after_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> ref_rdy);

    p_ref_change_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_int != $past(ref_int)) |-> !locked);

    p_status_moves_to_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_ref_int) |-> $past(stat_ref_int != ref_int));

    p_ffclk_loop_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd0) || (mode == 2'd1)) |-> ffclk_ok);

    p_trim_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !trim_wr |=> $stable(trim_coarse) && $stable(trim_fine));
endmodule

bind clkseq_ctrl clkseq_checker #(.REF_DIV_W(REF_DIV_W), .TRIM_W(TRIM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .trim_wr      (trim_wr),
    .mode         (mode),
    .ref_int      (ref_int),
    .ref_div      (ref_div),
    .ext_en       (ext_en),
    .stat_ref_int (stat_ref_int),
    .ref_rdy      (ref_rdy),
    .locked       (locked),
    .cfg_err      (cfg_err),
    .ffclk_ok     (ffclk_ok),
    .trim_coarse  (trim_coarse),
    .trim_fine    (trim_fine)
);

// File: tb/clkseq_ctrl_test.sv
`timescale 1ns/1ps
module clkseq_ctrl_test;
    localparam int STAB = 5;
    localparam int LOCK = 12;
    localparam int SWL  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_src_sel = 2'd0;
    logic       cfg_ref_int = 1'b1;
    logic [2:0] cfg_ref_div = 3'd0;
    logic [1:0] cfg_out_div = 2'd1;
    logic       cfg_ext_en = 1'b0;
    logic       trim_wr = 1'b0;
    logic [7:0] trim_coarse_in = 8'd0;
    logic       trim_fine_in = 1'b0;
    logic [1:0] mode, src_sel, out_div, stat_src;
    logic [2:0] ref_div;
    logic       ref_int, ext_en, stat_ref_int, ref_rdy, locked, cfg_err, ffclk_ok, trim_fine;
    logic [7:0] trim_coarse;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clkseq_ctrl #(.STAB_CYC(STAB), .LOCK_CYC(LOCK), .SW_LAT(SWL)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_src_sel(cfg_src_sel),
        .cfg_ref_int(cfg_ref_int), .cfg_ref_div(cfg_ref_div), .cfg_out_div(cfg_out_div),
        .cfg_ext_en(cfg_ext_en), .trim_wr(trim_wr), .trim_coarse_in(trim_coarse_in),
        .trim_fine_in(trim_fine_in), .mode(mode), .src_sel(src_sel), .ref_int(ref_int),
        .ref_div(ref_div), .out_div(out_div), .ext_en(ext_en), .stat_src(stat_src),
        .stat_ref_int(stat_ref_int), .ref_rdy(ref_rdy), .locked(locked), .cfg_err(cfg_err),
        .ffclk_ok(ffclk_ok), .trim_coarse(trim_coarse), .trim_fine(trim_fine)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_wr = 1'b0;
        trim_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int s, input int r, input int e, input int rd, input int od);
        @(negedge clk);
        cfg_src_sel = 2'(s);
        cfg_ref_int = 1'(r);
        cfg_ext_en  = 1'(e);
        cfg_ref_div = 3'(rd);
        cfg_out_div = 2'(od);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // expected mode after a write, -1 when the write must be rejected
    function automatic int exp_mode(input int cur, input int cur_e, input int s,
                                    input int r, input int e);
        int t;
        if (s == 0) t = (r == 1) ? 0 : 1;
        else if (s == 1 && r == 1) t = 3;
        else if (s == 2 && r == 0) t = 2;
        else return -1;
        if ((t == 1 || t == 2) && !(cur_e == 1 && e == 1)) return -1;
        if ((cur == 1 && t == 3) || (cur == 3 && t == 1)) return -1;
        return t;
    endfunction

    initial begin
        #(5.0 * 150000);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 mode", mode, 0);
        chk("R1 src", src_sel, 0);
        chk("R1 ref_int", ref_int, 1);
        chk("R1 ref_div", ref_div, 0);
        chk("R1 out_div", out_div, 1);
        chk("R1 ext_en", ext_en, 0);
        chk("R1 stat", {stat_src, stat_ref_int}, 1);
        chk("R1 err", cfg_err, 0);
        chk("R1 trim", {trim_coarse, trim_fine}, 256);

        // R6 stabilisation then lock timing
        for (int k = 1; k <= STAB + LOCK; k++) begin
            @(negedge clk);
            if (k == STAB - 1) chk("R6 rdy early", ref_rdy, 0);
            if (k == STAB)     chk("R6 rdy", ref_rdy, 1);
            if (k == STAB + LOCK - 1) chk("R6 lock early", locked, 0);
        end
        chk("R6 lock", locked, 1);

        // R7 relock on reference change only
        wr(1, 1, 0, 0, 1);
        chk("R7 same ref keeps lock", locked, 1);
        wr(0, 1, 1, 0, 1);
        wr(0, 0, 1, 0, 1);
        chk("R7 mode ext loop", mode, 1);
        chk("R7 unlock", locked, 0);
        repeat (LOCK - 1) @(negedge clk);
        chk("R7 relock early", locked, 0);
        @(negedge clk);
        chk("R7 relock", locked, 1);

        // R10 trim only on trim write
        chk("R10 trim after cfg", {trim_coarse, trim_fine}, 256);
        @(negedge clk);
        trim_coarse_in = 8'h3C; trim_fine_in = 1'b1; trim_wr = 1'b1;
        @(negedge clk);
        trim_wr = 1'b0; trim_coarse_in = 8'h11; trim_fine_in = 1'b0;
        chk("R10 trim load", {trim_coarse, trim_fine}, 8'h3C * 2 + 1);
        repeat (3) @(negedge clk);
        chk("R10 trim hold", {trim_coarse, trim_fine}, 8'h3C * 2 + 1);

        // R8 status latency
        do_reset();
        wr(1, 1, 0, 0, 1);
        chk("R8 ctrl immediate", src_sel, 1);
        for (int n = 0; n < SWL; n++) begin
            chk("R8 status old", stat_src, 0);
            @(negedge clk);
        end
        chk("R8 status new", stat_src, 1);
        chk("R8 status ref", stat_ref_int, 1);

        // R2 R3 R4 R5 sweep: every start mode against every write
        for (int st = 0; st < 4; st++) begin
            for (int s = 0; s < 4; s++) begin
                for (int r = 0; r < 2; r++) begin
                    for (int e = 0; e < 2; e++) begin
                        int ce;
                        int em;
                        do_reset();
                        ce = 0;
                        if (st == 1) begin wr(0, 1, 1, 0, 1); wr(0, 0, 1, 0, 1); ce = 1; end
                        if (st == 2) begin wr(0, 1, 1, 0, 1); wr(2, 0, 1, 0, 1); ce = 1; end
                        if (st == 3) wr(1, 1, 0, 0, 1);
                        chk("R2 start mode", mode, st);
                        em = exp_mode(st, ce, s, r, e);
                        wr(s, r, e, 5, 2);
                        chk("R3 R4 mode after write", mode, (em < 0) ? st : em);
                        chk("R5 err pulse", cfg_err, (em < 0) ? 1 : 0);
                        chk("R5 divider", ref_div, (em < 0) ? 0 : 5);
                        @(negedge clk);
                        chk("R5 err one cycle", cfg_err, 0);
                    end
                end
            end
        end

        // R9 fixed-frequency flag per mode and divider pair
        do_reset();
        for (int m = 0; m < 3; m++) begin
            int ms;
            int mr;
            ms = (m == 0) ? 0 : (m == 1) ? 2 : 1;
            mr = (m == 1) ? 0 : 1;
            for (int od = 0; od < 4; od++) begin
                for (int rd = 0; rd < 8; rd++) begin
                    int ev;
                    wr(ms, mr, 1, rd, od);
                    ev = 1;
                    if (m != 0 && ((od == 0 && rd < 2) || (od == 1 && rd < 3))) ev = 0;
                    chk("R9 ffclk_ok", ffclk_ok, ev);
                end
            end
        end

        finish_up();
    end
endmodule